// File: doc/BRIEF.md
# Bridge Primary Status Register

This block holds the 16-bit primary status register of a bridge function. Six flag bits are sticky. Error and abort events reported by the upstream and downstream interface logic set them, and software clears them by writing ones through a configuration port. The register decodes at byte offsets 06h and 07h. One bit always reads as one, and every other bit that is not a flag always reads as zero.

Two of the parity flags depend on the parity-error-response enable, which comes from the companion command register. A third parity flag ignores that enable. When a downstream parity error is recorded while the system-error enable is also on, a three-state machine sends a single system-error request. It sends it either as an NMI or as an SMI, depending on a routing input. The machine's states are IDLE, FIRE and HOLD:

- IDLE moves to FIRE when the qualified condition is present.
- FIRE moves to HOLD if the condition is still present, and back to IDLE otherwise.
- HOLD moves to IDLE once the condition drops.

The request is driven only in FIRE. The received-target-abort flag is also brought out on a pin, so that monitoring logic can act on it.

Top module: `bridge_pri_status`

## Requirements
- R1: After reset the register reads 16'h0080 at byte address 06h or 07h, and `serr_nmi`, `serr_smi` and `rx_tabort_flag` are low.
- R2: Bit 7 always reads 1. Bits 10:9, 6, 5 and 4:0 always read 0, whatever is written.
- R3: Bit 15 sets on the clock edge that samples `up_parity_err`, whatever the value of `cmd_perr_resp`.
- R4: Bit 14 sets on an edge that samples `dn_parity_err` only when `cmd_perr_resp` is 1. Otherwise it stays unchanged.
- R5: Bit 8 sets on an edge that samples `up_parity_err` only when `cmd_perr_resp` is 1.
- R6: Bits 13, 12 and 11 set on `up_rx_master_abort`, `up_rx_target_abort` and `up_sig_target_abort` respectively.
- R7: A write to a flag bit clears it when the write data bit is 1 and leaves it unchanged when the bit is 0. A write takes effect only when `cfg_addr[7:1]` equals 7'h03.
- R8: `cfg_be[1]` gates writes to bits 15:8 and `cfg_be[0]` gates writes to bits 7:0. A write with `cfg_be[1]`=0 leaves every flag unchanged.
- R9: If a set event and a clearing write reach the same bit on the same edge, the bit ends up set.
- R10: A request pulse of exactly one cycle follows the edge where `dn_parity_err & cmd_perr_resp & cmd_serr_en` is first sampled true after being false (or after reset). The pulse appears in the same cycle as the bit 14 update. A condition that stays true gives only one pulse.
- R11: The pulse appears on `serr_smi` when `route_nmi_to_smi` is 1 and on `serr_nmi` when it is 0. The two outputs are never high together.
- R12: `rx_tabort_flag` follows bit 12 of the register.
- R13: `cfg_rdata` reads 0 when `cfg_addr[7:1]` is not 7'h03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data (1 clears a flag) |
| cfg_rdata | output | 16 | Read data, combinational from the address |
| cmd_perr_resp | input | 1 | Parity-error-response enable from the command register |
| cmd_serr_en | input | 1 | System-error enable from the command register |
| route_nmi_to_smi | input | 1 | Selects SMI instead of NMI for the request |
| up_parity_err | input | 1 | Parity error detected on the upstream interface |
| dn_parity_err | input | 1 | Address, command or special-cycle data parity error on the downstream bus |
| up_rx_master_abort | input | 1 | Master abort received from the upstream device |
| up_rx_target_abort | input | 1 | Target abort received from the upstream device |
| up_sig_target_abort | input | 1 | Target abort signaled on the upstream interface |
| serr_nmi | output | 1 | One-cycle system-error request as NMI |
| serr_smi | output | 1 | One-cycle system-error request as SMI |
| rx_tabort_flag | output | 1 | Copy of the received-target-abort flag |

## Verification
Two situations are the hardest to reach from the ports. The first is a set event and a clearing write that land on the same bit on the same edge. The second is a qualified system-error condition that is held over several cycles, then dropped and raised again. Directed sequences create both situations on purpose. After those, a seeded random phase runs with event probabilities kept low and write addresses biased toward 06h and 07h. This drives the random phase through those collisions many more times, under shifting enables, byte enables and routing.

// File: rtl/bps_pkg.sv
`timescale 1ns/1ps
package bps_pkg;
    localparam int STAT_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = STAT_W / BYTE_W;
    localparam int NUM_FLAGS = 6;

    // flag index -> register bit position
    localparam int FL_UP_PERR  = 0;
    localparam int FL_DN_SERR  = 1;
    localparam int FL_RX_MABT  = 2;
    localparam int FL_RX_TABT  = 3;
    localparam int FL_SIG_TABT = 4;
    localparam int FL_UP_MPERR = 5;

    localparam logic [STAT_W-1:0] FIXED_ONES = 16'h0080;

    function automatic int flag_pos(input int idx);
        int pos;
        case (idx)
            FL_UP_PERR:  pos = 15;
            FL_DN_SERR:  pos = 14;
            FL_RX_MABT:  pos = 13;
            FL_RX_TABT:  pos = 12;
            FL_SIG_TABT: pos = 11;
            default:     pos = 8;
        endcase
        return pos;
    endfunction

    function automatic logic [STAT_W-1:0] writable_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FLAGS; i++) m[flag_pos(i)] = 1'b1;
        return m;
    endfunction

    typedef enum logic [1:0] {
        SERR_IDLE = 2'd0,
        SERR_FIRE = 2'd1,
        SERR_HOLD = 2'd2
    } serr_state_e;
endpackage

// File: rtl/bps_flag_cell.sv
`timescale 1ns/1ps
module bps_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/bps_wr_decode.sv
`timescale 1ns/1ps
module bps_wr_decode
    import bps_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [NUM_BYTES-1:0] cfg_be,
    input  logic [STAT_W-1:0]    cfg_wdata,
    output logic                 addr_hit,
    output logic [STAT_W-1:0]    clr_mask
);
    localparam int WORD_LSB = $clog2(NUM_BYTES);

    logic wr_hit;
    logic unused_addr_lsb;

    assign addr_hit        = (cfg_addr[ADDR_W-1:WORD_LSB] == REG_OFFSET[ADDR_W-1:WORD_LSB]);
    assign wr_hit          = cfg_wr & addr_hit;
    assign unused_addr_lsb = ^cfg_addr[WORD_LSB-1:0];

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign clr_mask[b*BYTE_W +: BYTE_W] =
            {BYTE_W{wr_hit & cfg_be[b]}} & cfg_wdata[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/bps_serr_fsm.sv
`timescale 1ns/1ps
module bps_serr_fsm
    import bps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic route_smi_i,
    output logic nmi_o,
    output logic smi_o
);
    serr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SERR_IDLE: if (cond_i) state_d = SERR_FIRE;
            SERR_FIRE: state_d = cond_i ? SERR_HOLD : SERR_IDLE;
            SERR_HOLD: if (!cond_i) state_d = SERR_IDLE;
            default:   state_d = SERR_IDLE;
        endcase
    end

    always_comb begin
        nmi_o = 1'b0;
        smi_o = 1'b0;
        unique case (state_q)
            SERR_FIRE: begin
                if (route_smi_i) smi_o = 1'b1;
                else             nmi_o = 1'b1;
            end
            SERR_IDLE, SERR_HOLD: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/bridge_pri_status.sv
`timescale 1ns/1ps
module bridge_pri_status
    import bps_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic [NUM_BYTES-1:0] cfg_be,
    input  logic [STAT_W-1:0]    cfg_wdata,
    output logic [STAT_W-1:0]    cfg_rdata,
    input  logic                 cmd_perr_resp,
    input  logic                 cmd_serr_en,
    input  logic                 route_nmi_to_smi,
    input  logic                 up_parity_err,
    input  logic                 dn_parity_err,
    input  logic                 up_rx_master_abort,
    input  logic                 up_rx_target_abort,
    input  logic                 up_sig_target_abort,
    output logic                 serr_nmi,
    output logic                 serr_smi,
    output logic                 rx_tabort_flag
);
    localparam logic [STAT_W-1:0] WR_MASK = writable_mask();

    logic                 addr_hit;
    logic [STAT_W-1:0]    clr_mask;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [STAT_W-1:0]    status_q;
    logic                 serr_cond;
    logic                 unused_clr_bits;

    bps_wr_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) i_decode (
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .addr_hit  (addr_hit),
        .clr_mask  (clr_mask)
    );

    // hardwired bits accept writes and discard them
    assign unused_clr_bits = ^(clr_mask & ~WR_MASK);

    always_comb begin
        set_vec              = '0;
        set_vec[FL_UP_PERR]  = up_parity_err;
        set_vec[FL_DN_SERR]  = dn_parity_err & cmd_perr_resp;
        set_vec[FL_RX_MABT]  = up_rx_master_abort;
        set_vec[FL_RX_TABT]  = up_rx_target_abort;
        set_vec[FL_SIG_TABT] = up_sig_target_abort;
        set_vec[FL_UP_MPERR] = up_parity_err & cmd_perr_resp;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam int POS = flag_pos(i);
        bps_flag_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_mask[POS]),
            .flag_o (flag_q[i])
        );
    end

    always_comb begin
        status_q = FIXED_ONES;
        for (int i = 0; i < NUM_FLAGS; i++) status_q[flag_pos(i)] = flag_q[i];
    end

    assign cfg_rdata      = addr_hit ? status_q : '0;
    assign rx_tabort_flag = flag_q[FL_RX_TABT];
    assign serr_cond      = dn_parity_err & cmd_perr_resp & cmd_serr_en;

    bps_serr_fsm i_serr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_i      (serr_cond),
        .route_smi_i (route_nmi_to_smi),
        .nmi_o       (serr_nmi),
        .smi_o       (serr_smi)
    );
endmodule

// File: rtl/bps_checker.sv
`timescale 1ns/1ps
module bps_checker
    import bps_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    cfg_addr,
    input logic                 cfg_wr,
    input logic [NUM_BYTES-1:0] cfg_be,
    input logic [STAT_W-1:0]    cfg_wdata,
    input logic [STAT_W-1:0]    cfg_rdata,
    input logic                 cmd_perr_resp,
    input logic                 cmd_serr_en,
    input logic                 route_nmi_to_smi,
    input logic                 up_parity_err,
    input logic                 dn_parity_err,
    input logic                 up_rx_master_abort,
    input logic                 up_rx_target_abort,
    input logic                 up_sig_target_abort,
    input logic                 serr_nmi,
    input logic                 serr_smi,
    input logic                 rx_tabort_flag,
    input logic [STAT_W-1:0]    status_q
);
    logic hit;
    assign hit = (cfg_addr[ADDR_W-1:1] == REG_OFFSET[ADDR_W-1:1]);

    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cfg_rdata[7] && ((cfg_rdata & 16'h067F) == 16'h0000)));

    a_r13_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cfg_rdata == '0));

    a_r3_dpe_set: assert property (@(posedge clk) disable iff (!rst_n)
        up_parity_err |=> status_q[15]);

    a_r4_sse_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q[14] && !(dn_parity_err && cmd_perr_resp)) |=> !status_q[14]);

    a_r5_mdpe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q[8] && !(up_parity_err && cmd_perr_resp)) |=> !status_q[8]);

    a_r6_rma_set: assert property (@(posedge clk) disable iff (!rst_n)
        up_rx_master_abort |=> status_q[13]);

    a_r6_sta_set: assert property (@(posedge clk) disable iff (!rst_n)
        up_sig_target_abort |=> status_q[11]);

    a_r7_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && hit && cfg_be[1] && cfg_wdata[13] && !up_rx_master_abort)
        |=> !status_q[13]);

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_nmi || serr_smi) |=> !(serr_nmi || serr_smi));

    a_r10_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_parity_err && cmd_perr_resp && cmd_serr_en) |=> !(serr_nmi || serr_smi));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({serr_nmi, serr_smi}));

    a_r11_smi_route: assert property (@(posedge clk) disable iff (!rst_n)
        serr_smi |-> route_nmi_to_smi);

    a_r12_rta_out: assert property (@(posedge clk) disable iff (!rst_n)
        up_rx_target_abort |=> rx_tabort_flag);
endmodule

bind bridge_pri_status bps_checker #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) i_bps_checker (
    .clk                 (clk),
    .rst_n               (rst_n),
    .cfg_addr            (cfg_addr),
    .cfg_wr              (cfg_wr),
    .cfg_be              (cfg_be),
    .cfg_wdata           (cfg_wdata),
    .cfg_rdata           (cfg_rdata),
    .cmd_perr_resp       (cmd_perr_resp),
    .cmd_serr_en         (cmd_serr_en),
    .route_nmi_to_smi    (route_nmi_to_smi),
    .up_parity_err       (up_parity_err),
    .dn_parity_err       (dn_parity_err),
    .up_rx_master_abort  (up_rx_master_abort),
    .up_rx_target_abort  (up_rx_target_abort),
    .up_sig_target_abort (up_sig_target_abort),
    .serr_nmi            (serr_nmi),
    .serr_smi            (serr_smi),
    .rx_tabort_flag      (rx_tabort_flag),
    .status_q            (status_q)
);

// File: tb/test_bridge_pri_status.sv
`timescale 1ns/1ps
module test_bridge_pri_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = 8'h06;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cmd_perr_resp = 1'b0, cmd_serr_en = 1'b0, route_nmi_to_smi = 1'b0;
    logic        up_parity_err = 1'b0, dn_parity_err = 1'b0;
    logic        up_rx_master_abort = 1'b0, up_rx_target_abort = 1'b0, up_sig_target_abort = 1'b0;
    logic        serr_nmi, serr_smi, rx_tabort_flag;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;
    logic [15:0] exp_flags = '0;
    logic        prev_cond = 1'b0;

    always #4 clk = ~clk;

    bridge_pri_status i_bridge_pri_status (
        .clk (clk), .rst_n (rst_n),
        .cfg_addr (cfg_addr), .cfg_wr (cfg_wr), .cfg_be (cfg_be),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .cmd_perr_resp (cmd_perr_resp), .cmd_serr_en (cmd_serr_en),
        .route_nmi_to_smi (route_nmi_to_smi),
        .up_parity_err (up_parity_err), .dn_parity_err (dn_parity_err),
        .up_rx_master_abort (up_rx_master_abort),
        .up_rx_target_abort (up_rx_target_abort),
        .up_sig_target_abort (up_sig_target_abort),
        .serr_nmi (serr_nmi), .serr_smi (serr_smi),
        .rx_tabort_flag (rx_tabort_flag)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected next flag state from the requirements
    function automatic logic [15:0] next_flags(
        input logic [15:0] old, input logic up, dn, rma, rta, sta, pr,
        input logic wr, input logic [7:0] addr, input logic [1:0] be,
        input logic [15:0] wd);
        logic [15:0] set, clr;
        set = '0;
        set[15] = up;            // R3
        set[14] = dn & pr;       // R4
        set[13] = rma;           // R6
        set[12] = rta;
        set[11] = sta;
        set[8]  = up & pr;       // R5
        clr = '0;
        if (wr && addr[7:1] == 7'h03 && be[1]) clr = wd & 16'hF900;  // R7 R8
        return (old & ~clr) | set;  // R9
    endfunction

    task automatic step(input logic up, dn, rma, rta, sta, pr, se, rt,
                        input logic wr, input logic [7:0] addr,
                        input logic [1:0] be, input logic [15:0] wd,
                        input string tag);
        logic cond, pulse;
        @(negedge clk);
        up_parity_err = up; dn_parity_err = dn;
        up_rx_master_abort = rma; up_rx_target_abort = rta; up_sig_target_abort = sta;
        cmd_perr_resp = pr; cmd_serr_en = se; route_nmi_to_smi = rt;
        cfg_wr = wr; cfg_addr = addr; cfg_be = be; cfg_wdata = wd;
        cond  = dn & pr & se;
        pulse = cond & ~prev_cond;
        prev_cond = cond;
        exp_flags = next_flags(exp_flags, up, dn, rma, rta, sta, pr, wr, addr, be, wd);
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        cfg_addr = 8'h06;
        #1;
        chk({tag, " reg"}, cfg_rdata, exp_flags | 16'h0080);
        chk({tag, " serr(R10/R11)"}, {14'b0, serr_smi, serr_nmi},
            {14'b0, pulse & rt, pulse & ~rt});
        chk({tag, " rta(R12)"}, {15'b0, rx_tabort_flag}, {15'b0, exp_flags[12]});
    endtask

    task automatic idle(input string tag);
        step(0,0,0,0,0, cmd_perr_resp, cmd_serr_en, route_nmi_to_smi, 0, 8'h06, 2'b00, 16'h0, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog (all): actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h1234_5EED;
        void'($urandom(seed));

        // R1 reset state
        #10;
        cfg_addr = 8'h06; #1;
        chk("R1 reset read 06", cfg_rdata, 16'h0080);
        cfg_addr = 8'h07; #1;
        chk("R1 reset read 07", cfg_rdata, 16'h0080);
        chk("R1 reset outputs", {13'b0, serr_nmi, serr_smi, rx_tabort_flag}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R13 other addresses read zero
        cfg_addr = 8'h04; #1;
        chk("R13 read 04", cfg_rdata, 16'h0);
        cfg_addr = 8'h08; #1;
        chk("R13 read 08", cfg_rdata, 16'h0);

        // R3 upstream parity without enable, then R5 with enable
        step(1,0,0,0,0, 0,0,0, 0,8'h06,2'b00,16'h0, "R3 dpe no enable");
        step(1,0,0,0,0, 1,0,0, 0,8'h06,2'b00,16'h0, "R5 mdpe enabled");
        // R4 downstream parity gated
        step(0,1,0,0,0, 0,0,0, 0,8'h06,2'b00,16'h0, "R4 sse gated off");
        step(0,1,0,0,0, 1,0,0, 0,8'h06,2'b00,16'h0, "R4 sse enabled");
        // R6 aborts, R12 rta pin
        step(0,0,1,0,0, 0,0,0, 0,8'h06,2'b00,16'h0, "R6 rma");
        step(0,0,0,1,0, 0,0,0, 0,8'h06,2'b00,16'h0, "R12 rta");
        step(0,0,0,0,1, 0,0,0, 0,8'h06,2'b00,16'h0, "R6 sta");
        // R7 zeros and misses change nothing
        step(0,0,0,0,0, 0,0,0, 1,8'h06,2'b11,16'h0000, "R7 write zeros");
        step(0,0,0,0,0, 0,0,0, 1,8'h04,2'b11,16'hFFFF, "R7 miss address");
        // R8 byte enables
        step(0,0,0,0,0, 0,0,0, 1,8'h06,2'b01,16'hFFFF, "R8 low byte only");
        step(0,0,0,0,0, 0,0,0, 1,8'h07,2'b10,16'h2000, "R7 clear bit13 via 07");
        step(0,0,0,0,0, 0,0,0, 1,8'h06,2'b11,16'hFFFF, "R2 clear all, fixed bits stay");
        // R9 set beats clear
        step(0,0,1,0,0, 0,0,0, 1,8'h06,2'b10,16'hFF00, "R9 set wins");
        // R10 held condition pulses once, R11 routing
        step(0,1,0,0,0, 1,1,0, 0,8'h06,2'b00,16'h0, "R10 cond rise nmi");
        step(0,1,0,0,0, 1,1,0, 0,8'h06,2'b00,16'h0, "R10 cond held");
        step(0,1,0,0,0, 1,1,0, 0,8'h06,2'b00,16'h0, "R10 cond held 2");
        step(0,0,0,0,0, 1,1,1, 0,8'h06,2'b00,16'h0, "R10 cond drop");
        step(0,1,0,0,0, 1,1,1, 0,8'h06,2'b00,16'h0, "R11 cond rise smi");
        step(0,1,0,0,0, 0,1,1, 0,8'h06,2'b00,16'h0, "R10 perr_resp off");
        idle("R10 idle");

        // constrained random phase
        for (int n = 0; n < 800; n++) begin
            logic [7:0] a;
            case ($urandom_range(3))
                0: a = 8'h06;
                1: a = 8'h07;
                2: a = 8'h04;
                default: a = 8'($urandom);
            endcase
            step($urandom_range(5) == 0, $urandom_range(3) == 0,
                 $urandom_range(5) == 0, $urandom_range(5) == 0,
                 $urandom_range(5) == 0,
                 $urandom_range(3) != 0, $urandom_range(2) != 0,
                 $urandom_range(7) == 0,
                 $urandom_range(2) == 0, a, 2'($urandom),
                 16'($urandom), "R9 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule